// File: doc/BRIEF.md
# SMBus Host Controller Register Front-End

This block is the software-facing register set of a PC-style SMBus host controller. Software sets up a target address, a command byte and up to two data bytes through byte-wide register accesses. It then writes the control register with a protocol code and the start bit. The block decodes the protocol and checks that it may run. It then hands one abstract transaction to a downstream bus engine and records the engine's outcome in a status register.

The bus engine sits outside the block. It takes a single-cycle request carrying the target address, direction, protocol, command and a 16-bit write word. It answers with a done pulse, an ack/nack flag and a 16-bit read word. The block also drives an interrupt request and handles the kill command. When interrupts are off, it holds a start back until software next reads the status register.

Top module: `smb_host_regs`

## Requirements
- R1: Register offsets are status 0x00, control 0x02, command 0x03, address 0x04, data-low 0x05, data-high 0x06, block byte 0x07 and auxiliary 0x0D. Command, address, data-low, data-high and block byte read back the value last written. Any other offset reads 0. Read data is valid in the same cycle as the read strobe.
- R2: Status bits are 0 busy, 1 done, 2 device error, 3 bus error, 4 failed, 5 alert, 6 in-use and 7 byte-done. A status write clears every bit written as 1, except busy, which a status write never clears.
- R3: Control bits are 0 interrupt enable, 1 kill, 4:2 protocol and 6 start. A control read returns only bits 4:0, so start always reads 0. The auxiliary register keeps only bits 1:0.
- R4: The request carries address bits 7:1 as the 7-bit target and the protocol code. Address bit 0 gives the direction (1 = read), except for protocol 6 (I2C block read), which always requests a read.
- R5: Protocol codes 0 quick, 1 byte, 2 byte-data, 3 word-data, 5 block and 6 I2C block read are executed. Codes 4 and 7 issue no request and set device error.
- R6: While device error is set, a start issues no request, leaves busy clear and sets device error again.
- R7: The write word is {data-high, data-low}. On an acked read, byte and byte-data load read bits 7:0 into data-low. Word-data loads bits 15:8 into data-high and bits 7:0 into data-low. Protocols 5 and 6 load bits 7:0 into the block byte.
- R8: When the engine reports done, busy clears. An ack sets done and a nack sets device error.
- R9: A start with interrupt enable 1 sets busy and raises the request for exactly the one cycle after the accepting edge. Busy stays set until done. A further start while waiting is ignored.
- R10: A start with interrupt enable 0 sets busy and issues no request. The next status read returns the status with busy set, and the pending transaction is requested in the following cycle.
- R11: The interrupt output is high only when interrupt enable is 1 and a status bit other than busy is set.
- R12: A control write with kill set sets failed, clears busy and abandons the transaction. A later done from the engine then changes neither status nor data.
- R13: After reset, status reads 0 and the interrupt and request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read side effects) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, same cycle |
| irq | output | 1 | Interrupt request |
| eng_req | output | 1 | One-cycle transaction request to the bus engine |
| eng_addr | output | TADDR_W | 7-bit target address |
| eng_rd | output | 1 | Direction of the request, 1 = read |
| eng_prot | output | PROT_W | Protocol code of the request |
| eng_cmd | output | DATA_W | Command byte |
| eng_wdata | output | 2*DATA_W | Write word {data-high, data-low} |
| eng_done | input | 1 | Engine finished the request |
| eng_ack | input | 1 | Engine outcome, 1 = ack, 0 = nack |
| eng_rdata | input | 2*DATA_W | Engine read word |

## Verification
Read data is combinational, so the bench samples it one nanosecond after it drives the strobe, before the edge that applies any status-read side effect. Register, status and data updates from a write, a status read or an engine done become visible right after the edge that takes them. The bench therefore checks them at the next falling edge. The request pulse belongs to the cycle after the accepting edge, and the bench checks it at the falling edge that ends the accepting write or the launching status read. Because the interrupt is combinational in the default variant, it is checked together with the status that drives it.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

   // register byte offsets
   localparam int OFF_STS = 0;
   localparam int OFF_CTL = 2;
   localparam int OFF_CMD = 3;
   localparam int OFF_ADR = 4;
   localparam int OFF_DLO = 5;
   localparam int OFF_DHI = 6;
   localparam int OFF_BLK = 7;
   localparam int OFF_AUX = 13;

   // status bit positions
   localparam int ST_BUSY   = 0;
   localparam int ST_DONE   = 1;
   localparam int ST_DEVERR = 2;
   localparam int ST_FAIL   = 4;

   // control bit positions
   localparam int CT_IEN     = 0;
   localparam int CT_KILL    = 1;
   localparam int CT_PROT_LO = 2;
   localparam int CT_PROT_HI = 4;
   localparam int CT_KEEP    = 5;   // bits kept in the control register
   localparam int CT_START   = 6;

   localparam int AUX_KEEP   = 2;

   typedef enum logic [2:0] {
      PR_QUICK  = 3'd0,
      PR_BYTE   = 3'd1,
      PR_BDATA  = 3'd2,
      PR_WORD   = 3'd3,
      PR_PCALL  = 3'd4,
      PR_BLOCK  = 3'd5,
      PR_I2CBLK = 3'd6,
      PR_RSVD   = 3'd7
   } prot_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_DEFER = 2'd1,
      SQ_WAIT  = 2'd2
   } seq_e;

   typedef struct packed {
      logic exec_ok;
      logic rd;
      logic ret_lo;
      logic ret_hi;
      logic ret_blk;
   } prot_info_t;

endpackage

// File: rtl/smb_prot_decode.sv
module smb_prot_decode
   import smb_host_pkg::*;
#(
   parameter int PROT_W     = 3,
   parameter bit I2C_BLK_EN = 1'b1
) (
   input  logic [PROT_W-1:0] prot,
   input  logic              dir_rd,
   output prot_info_t        info
);

   logic blk_ok;

   generate
      if (I2C_BLK_EN) begin : g_i2c_blk
         assign blk_ok = 1'b1;
      end else begin : g_no_i2c_blk
         assign blk_ok = 1'b0;
      end
   endgenerate

   prot_e code;
   logic  eff_rd;

   always_comb begin
      code    = prot_e'(prot);
      eff_rd  = (code == PR_I2CBLK) ? 1'b1 : dir_rd;
      info    = '0;
      info.rd = eff_rd;
      case (code)
         PR_QUICK, PR_BYTE, PR_BDATA, PR_WORD, PR_BLOCK: info.exec_ok = 1'b1;
         PR_I2CBLK: info.exec_ok = blk_ok;
         default:   info.exec_ok = 1'b0;
      endcase
      info.ret_lo  = eff_rd && (code == PR_BYTE || code == PR_BDATA || code == PR_WORD);
      info.ret_hi  = eff_rd && (code == PR_WORD);
      info.ret_blk = eff_rd && (code == PR_BLOCK || code == PR_I2CBLK);
   end

endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq
   import smb_host_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_wr,
   input  logic kill,
   input  logic ien_now,
   input  logic sts_rd,
   input  logic dev_err,
   input  logic exec_ok,
   input  logic eng_done,
   output logic busy,
   output logic eng_req,
   output logic go,
   output logic done_take,
   output logic refuse
);

   seq_e state_q;
   logic launch, defer;

   always_comb begin
      launch    = (start_wr && ien_now && state_q != SQ_WAIT) ||
                  (sts_rd && state_q == SQ_DEFER);
      defer     = start_wr && !ien_now && state_q != SQ_WAIT;
      go        = !kill && launch && !dev_err && exec_ok;
      refuse    = !kill && launch && (dev_err || !exec_ok);
      done_take = !kill && state_q == SQ_WAIT && eng_done;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         busy    <= 1'b0;
         eng_req <= 1'b0;
      end else begin
         eng_req <= go;
         if (kill || done_take || refuse) begin
            state_q <= SQ_IDLE;
            busy    <= 1'b0;
         end else if (go) begin
            state_q <= SQ_WAIT;
            busy    <= 1'b1;
         end else if (defer) begin
            state_q <= SQ_DEFER;
            busy    <= 1'b1;
         end
      end
   end

   // R9: the request is a single-cycle pulse
   a_r9_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |=> !eng_req);

   // R9: busy is high whenever a request goes out
   a_r9_req_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> busy);

   // R2: busy only drops on done, kill or a refused launch
   a_r2_busy_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(kill || done_take || refuse));

endmodule

// File: rtl/smb_irq_gen.sv
module smb_irq_gen #(
   parameter int  NSTS    = 7,
   parameter bit  IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ien,
   input  logic [NSTS-1:0] sts_flags,
   output logic            irq
);

   logic irq_raw;
   assign irq_raw = ien && (|sts_flags);

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_raw;
         end
         // R11: no interrupt without enable
         a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(ien) |-> !irq);
      end else begin : g_irq_comb
         assign irq = irq_raw;
         // R11: no interrupt without enable
         a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !ien |-> !irq);
      end
   endgenerate

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
   import smb_host_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 8,
   parameter int TADDR_W    = 7,
   parameter int PROT_W     = 3,
   parameter bit I2C_BLK_EN = 1'b1,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic                  irq,
   output logic                  eng_req,
   output logic [TADDR_W-1:0]    eng_addr,
   output logic                  eng_rd,
   output logic [PROT_W-1:0]     eng_prot,
   output logic [DATA_W-1:0]     eng_cmd,
   output logic [2*DATA_W-1:0]   eng_wdata,
   input  logic                  eng_done,
   input  logic                  eng_ack,
   input  logic [2*DATA_W-1:0]   eng_rdata
);

   localparam int NSTS = DATA_W - 1;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("smb_host_regs: DATA_W must be 8");
      end
      if (TADDR_W != DATA_W - 1) begin : g_bad_taddr_w
         $error("smb_host_regs: TADDR_W must be DATA_W-1");
      end
      if (PROT_W != CT_PROT_HI - CT_PROT_LO + 1) begin : g_bad_prot_w
         $error("smb_host_regs: PROT_W must match the control protocol field");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("smb_host_regs: ADDR_W must reach offset 0x0D");
      end
   endgenerate

   // register storage
   logic [DATA_W-1:1]   sts_q;
   logic [CT_KEEP-1:0]  ctl_q;
   logic [DATA_W-1:0]   cmd_q, adr_q, dlo_q, dhi_q, blk_q;
   logic [AUX_KEEP-1:0] aux_q;
   logic [PROT_W-1:0]   prot_q;
   logic                rd_q, lo_q, hi_q, blkret_q;

   // access decode
   logic wr_sts, wr_ctl, rd_sts;
   assign wr_sts = reg_wr && reg_addr == ADDR_W'(OFF_STS);
   assign wr_ctl = reg_wr && reg_addr == ADDR_W'(OFF_CTL);
   assign rd_sts = reg_rd && reg_addr == ADDR_W'(OFF_STS);

   logic start_wr, kill, ien_now;
   assign start_wr = wr_ctl && reg_wdata[CT_START];
   assign kill     = wr_ctl && reg_wdata[CT_KILL];
   assign ien_now  = wr_ctl ? reg_wdata[CT_IEN] : ctl_q[CT_IEN];

   // the protocol a launch uses: the one being written, else the stored one
   logic [PROT_W-1:0] prot_sel;
   assign prot_sel = wr_ctl ? reg_wdata[CT_PROT_HI:CT_PROT_LO]
                            : ctl_q[CT_PROT_HI:CT_PROT_LO];

   prot_info_t info;

   smb_prot_decode #(
      .PROT_W     (PROT_W),
      .I2C_BLK_EN (I2C_BLK_EN)
   ) u_decode (
      .prot   (prot_sel),
      .dir_rd (adr_q[0]),
      .info   (info)
   );

   logic busy, go, done_take, refuse;

   smb_txn_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_wr  (start_wr),
      .kill      (kill),
      .ien_now   (ien_now),
      .sts_rd    (rd_sts),
      .dev_err   (sts_q[ST_DEVERR]),
      .exec_ok   (info.exec_ok),
      .eng_done  (eng_done),
      .busy      (busy),
      .eng_req   (eng_req),
      .go        (go),
      .done_take (done_take),
      .refuse    (refuse)
   );

   // next status: software clears first, events set afterwards
   logic [DATA_W-1:1] sts_nxt;
   always_comb begin
      sts_nxt = sts_q;
      if (wr_sts) sts_nxt = sts_nxt & ~reg_wdata[DATA_W-1:1];
      if (done_take) begin
         if (eng_ack) sts_nxt[ST_DONE]   = 1'b1;
         else         sts_nxt[ST_DEVERR] = 1'b1;
      end
      if (refuse) sts_nxt[ST_DEVERR] = 1'b1;
      if (kill)   sts_nxt[ST_FAIL]   = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q    <= '0;
         ctl_q    <= '0;
         cmd_q    <= '0;
         adr_q    <= '0;
         dlo_q    <= '0;
         dhi_q    <= '0;
         blk_q    <= '0;
         aux_q    <= '0;
         prot_q   <= '0;
         rd_q     <= 1'b0;
         lo_q     <= 1'b0;
         hi_q     <= 1'b0;
         blkret_q <= 1'b0;
      end else begin
         sts_q <= sts_nxt;
         if (wr_ctl) ctl_q <= reg_wdata[CT_KEEP-1:0];
         if (reg_wr) begin
            case (reg_addr)
               ADDR_W'(OFF_CMD): cmd_q <= reg_wdata;
               ADDR_W'(OFF_ADR): adr_q <= reg_wdata;
               ADDR_W'(OFF_DLO): dlo_q <= reg_wdata;
               ADDR_W'(OFF_DHI): dhi_q <= reg_wdata;
               ADDR_W'(OFF_BLK): blk_q <= reg_wdata;
               ADDR_W'(OFF_AUX): aux_q <= reg_wdata[AUX_KEEP-1:0];
               default: ;
            endcase
         end
         if (go) begin
            prot_q   <= prot_sel;
            rd_q     <= info.rd;
            lo_q     <= info.ret_lo;
            hi_q     <= info.ret_hi;
            blkret_q <= info.ret_blk;
         end
         if (done_take && eng_ack) begin
            if (lo_q)     dlo_q <= eng_rdata[DATA_W-1:0];
            if (hi_q)     dhi_q <= eng_rdata[2*DATA_W-1:DATA_W];
            if (blkret_q) blk_q <= eng_rdata[DATA_W-1:0];
         end
      end
   end

   // read mux
   always_comb begin
      case (reg_addr)
         ADDR_W'(OFF_STS): reg_rdata = {sts_q, busy};
         ADDR_W'(OFF_CTL): reg_rdata = DATA_W'(ctl_q);
         ADDR_W'(OFF_CMD): reg_rdata = cmd_q;
         ADDR_W'(OFF_ADR): reg_rdata = adr_q;
         ADDR_W'(OFF_DLO): reg_rdata = dlo_q;
         ADDR_W'(OFF_DHI): reg_rdata = dhi_q;
         ADDR_W'(OFF_BLK): reg_rdata = blk_q;
         ADDR_W'(OFF_AUX): reg_rdata = DATA_W'(aux_q);
         default:          reg_rdata = '0;
      endcase
   end

   // engine request fields
   assign eng_addr  = adr_q[DATA_W-1:1];
   assign eng_rd    = rd_q;
   assign eng_prot  = prot_q;
   assign eng_cmd   = cmd_q;
   assign eng_wdata = {dhi_q, dlo_q};

   smb_irq_gen #(
      .NSTS    (NSTS),
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ien       (ctl_q[CT_IEN]),
      .sts_flags (sts_q),
      .irq       (irq)
   );

   // R6: no request leaves while device error was set at the launch edge
   a_r6_no_req_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> !$past(sts_q[ST_DEVERR]));

   // R5: only executable protocol codes reach the engine
   a_r5_valid_prot: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> (eng_prot != PROT_W'(PR_PCALL) && eng_prot != PROT_W'(PR_RSVD)));

   // R12: kill sets failed and drops busy
   a_r12_kill_effect: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (sts_q[ST_FAIL] && !busy));

   // R8: an accepted engine result always lands in status
   a_r8_result_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      done_take |=> (sts_q[ST_DONE] || sts_q[ST_DEVERR]));

endmodule

// File: tb/smb_host_regs_bench.sv
`timescale 1ns/1ps
module smb_host_regs_bench;

   localparam int AW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq;
   logic        eng_req;
   logic [6:0]  eng_addr;
   logic        eng_rd;
   logic [2:0]  eng_prot;
   logic [7:0]  eng_cmd;
   logic [15:0] eng_wdata;
   logic        eng_done = 1'b0;
   logic        eng_ack = 1'b0;
   logic [15:0] eng_rdata = '0;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] rv;

   always #4 clk = ~clk;   // 125 MHz

   smb_host_regs u_smb_host_regs (
      .clk (clk), .rst_n (rst_n),
      .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq (irq),
      .eng_req (eng_req), .eng_addr (eng_addr), .eng_rd (eng_rd),
      .eng_prot (eng_prot), .eng_cmd (eng_cmd), .eng_wdata (eng_wdata),
      .eng_done (eng_done), .eng_ack (eng_ack), .eng_rdata (eng_rdata)
   );

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks begin and end just after a falling edge
   task automatic wr(input int a, input logic [7:0] d);
      reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      reg_addr = AW'(a); reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic respond(input bit ack, input logic [15:0] data, input int lat);
      repeat (lat) @(negedge clk);
      eng_ack = ack; eng_rdata = data; eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0; eng_ack = 1'b0;
   endtask

   function automatic bit f_exec(input int p);
      return (p inside {0, 1, 2, 3, 5, 6});
   endfunction

   function automatic bit f_dir(input int p, input bit a0);
      return (p == 6) ? 1'b1 : a0;
   endfunction

   function automatic logic [7:0] f_ctl(input int p, input bit ien);
      return 8'h40 | 8'(p << 2) | {7'd0, ien};
   endfunction

   task automatic run_random();
      logic [7:0] ab, cm, d0, d1, bk, es, x;
      logic [15:0] rdat;
      int p, lat;
      bit ien, ack, rdir, launched;
      ab = 8'($urandom); cm = 8'($urandom); d0 = 8'($urandom);
      d1 = 8'($urandom); bk = 8'($urandom);
      p = int'($urandom % 8); ien = 1'($urandom); ack = ($urandom % 4) != 0;
      rdat = 16'($urandom); lat = 1 + int'($urandom % 4);
      rdir = f_dir(p, ab[0]);
      launched = 1'b0;
      wr(0, 8'hFE);
      wr(4, ab); wr(3, cm); wr(5, d0); wr(6, d1); wr(7, bk);
      wr(2, f_ctl(p, ien));
      if (ien) begin
         chk("R9 R5 request after start", 16'(eng_req), 16'(f_exec(p)));
         launched = f_exec(p);
      end else begin
         chk("R10 no request while deferred", 16'(eng_req), 16'd0);
         rd(0, x);
         chk("R10 deferred status shows busy", 16'(x), 16'h0001);
         chk("R10 R5 request after status read", 16'(eng_req), 16'(f_exec(p)));
         launched = f_exec(p);
      end
      if (!launched) begin
         rd(0, x);
         chk("R5 bad protocol sets device error", 16'(x), 16'h0004);
         return;
      end
      chk("R4 target address", 16'(eng_addr), 16'(ab[7:1]));
      chk("R4 direction", 16'(eng_rd), 16'(rdir));
      chk("R4 protocol", 16'(eng_prot), 16'(p));
      chk("R4 command", 16'(eng_cmd), 16'(cm));
      chk("R7 write word", eng_wdata, {d1, d0});
      rd(0, x);
      chk("R9 busy while waiting", 16'(x), 16'h0001);
      respond(ack, rdat, lat);
      es = ack ? 8'h02 : 8'h04;
      if (ack && rdir) begin
         if (p == 1 || p == 2 || p == 3) d0 = rdat[7:0];
         if (p == 3) d1 = rdat[15:8];
         if (p == 5 || p == 6) bk = rdat[7:0];
      end
      rd(0, x);
      chk("R8 status after done", 16'(x), 16'(es));
      chk("R11 irq", 16'(irq), 16'(ien));
      rd(5, x); chk("R7 data-low", 16'(x), 16'(d0));
      rd(6, x); chk("R7 data-high", 16'(x), 16'(d1));
      rd(7, x); chk("R7 block byte", 16'(x), 16'(bk));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5A17C3));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13: reset state
      rd(0, rv);
      chk("R13 status after reset", 16'(rv), 16'h0000);
      chk("R13 irq after reset", 16'(irq), 16'd0);
      chk("R13 request after reset", 16'(eng_req), 16'd0);

      // R1: unmapped offsets and plain registers
      rd(1, rv);  chk("R1 unmapped 0x01", 16'(rv), 16'h0000);
      rd(8, rv);  chk("R1 unmapped 0x08", 16'(rv), 16'h0000);
      rd(14, rv); chk("R1 unmapped 0x0E", 16'(rv), 16'h0000);
      wr(3, 8'hA5); rd(3, rv); chk("R1 command readback", 16'(rv), 16'h00A5);
      wr(4, 8'h3C); rd(4, rv); chk("R1 address readback", 16'(rv), 16'h003C);
      wr(5, 8'h5E); rd(5, rv); chk("R1 data-low readback", 16'(rv), 16'h005E);
      wr(6, 8'hE7); rd(6, rv); chk("R1 data-high readback", 16'(rv), 16'h00E7);
      wr(7, 8'h81); rd(7, rv); chk("R1 block readback", 16'(rv), 16'h0081);

      // R3: control and auxiliary masking
      wr(2, 8'hBD); rd(2, rv); chk("R3 control returns 4:0", 16'(rv), 16'h001D);
      chk("R11 enable without status bits", 16'(irq), 16'd0);
      wr(13, 8'hFF); rd(13, rv); chk("R3 aux keeps 1:0", 16'(rv), 16'h0003);

      // R12/R2: kill, then busy survives a status clear
      wr(2, 8'h02); rd(0, rv); chk("R12 kill sets failed", 16'(rv), 16'h0010);
      wr(4, 8'h20);
      wr(2, 8'h40);
      rd(2, rv); chk("R3 start reads 0", 16'(rv), 16'h0000);
      wr(0, 8'hFF);
      rd(0, rv); chk("R2 busy not cleared by write", 16'(rv), 16'h0001);
      chk("R10 launch after status read", 16'(eng_req), 16'd1);
      respond(1'b1, 16'h0000, 2);
      rd(0, rv); chk("R8 ack sets done", 16'(rv), 16'h0002);
      chk("R11 irq off with enable 0", 16'(irq), 16'd0);

      // R12: kill while waiting, late done ignored
      wr(0, 8'hFE); wr(5, 8'h11); wr(4, 8'h51);
      wr(2, f_ctl(2, 1'b1));
      chk("R9 request pulse", 16'(eng_req), 16'd1);
      wr(2, 8'h03);
      rd(0, rv); chk("R12 kill clears busy", 16'(rv), 16'h0010);
      chk("R11 irq on failed", 16'(irq), 16'd1);
      respond(1'b1, 16'h00EE, 1);
      rd(0, rv); chk("R12 late done ignored status", 16'(rv), 16'h0010);
      rd(5, rv); chk("R12 late done ignored data", 16'(rv), 16'h0011);

      // R9: second start while waiting ignored
      wr(0, 8'hFE);
      wr(2, f_ctl(2, 1'b1));
      chk("R9 first request", 16'(eng_req), 16'd1);
      wr(2, f_ctl(2, 1'b1));
      chk("R9 repeat start ignored", 16'(eng_req), 16'd0);
      rd(0, rv); chk("R9 still busy", 16'(rv), 16'h0001);
      respond(1'b1, 16'h0077, 1);
      rd(5, rv); chk("R7 byte-data read", 16'(rv), 16'h0077);

      // R6/R8: nack then blocked starts
      wr(0, 8'hFE);
      wr(2, f_ctl(2, 1'b1));
      respond(1'b0, 16'h0000, 1);
      rd(0, rv); chk("R8 nack sets device error", 16'(rv), 16'h0004);
      wr(2, f_ctl(0, 1'b1));
      chk("R6 no request on error", 16'(eng_req), 16'd0);
      rd(0, rv); chk("R6 busy stays clear", 16'(rv), 16'h0004);
      wr(2, f_ctl(0, 1'b0));
      rd(0, rv); chk("R6 deferred shows busy", 16'(rv), 16'h0005);
      chk("R6 deferred launch blocked", 16'(eng_req), 16'd0);
      rd(0, rv); chk("R6 error after deferred", 16'(rv), 16'h0004);

      // R4/R7: I2C block read forces read direction
      wr(0, 8'hFE); wr(4, 8'hA0); wr(5, 8'h42);
      wr(2, f_ctl(6, 1'b1));
      chk("R4 i2c block forces read", 16'(eng_rd), 16'd1);
      respond(1'b1, 16'h1234, 1);
      rd(7, rv); chk("R7 block byte from read", 16'(rv), 16'h0034);
      rd(5, rv); chk("R7 data-low untouched", 16'(rv), 16'h0042);

      // R7: word read
      wr(0, 8'hFE); wr(4, 8'h91);
      wr(2, f_ctl(3, 1'b1));
      respond(1'b1, 16'hBEEF, 3);
      rd(6, rv); chk("R7 word high", 16'(rv), 16'h00BE);
      rd(5, rv); chk("R7 word low", 16'(rv), 16'h00EF);

      for (int i = 0; i < 60; i++) run_random();

      finish_run();
   end

endmodule